// File: doc/BRIEF.md
# Conflict-Filled Selective Instruction Cache

This block sits between a program sequencer and a single program-memory bus that carries both instruction fetches and data transfers. When the sequencer fetches an instruction in a cycle with no data transfer on that bus, the fetch goes straight to the bus and the cache is not involved at all. When a fetch and a bus data transfer fall in the same cycle, the data transfer keeps the bus. The instruction then comes from the cache if it is held there. If it is not held there, the sequencer is stalled for one cycle, the word is read from the bus in the next cycle, and it is written into the cache.

Only instructions that lost the bus to a data transfer are ever stored. A tight loop whose body collides with data traffic therefore fills the cache during its first pass and runs with no stalls after that. Fetches that never collide take no cache space. The store has 16 sets of two ways, 32 entries in all. Each entry holds a valid bit, an address tag and a 48-bit instruction word. Each set has one bit that marks its least recently used way. An enable input stops allocation and forces misses. A flush input invalidates every entry in one cycle.

Top module: `conflict_icache`

## Requirements
- R1: With `fetch_req`=1, `pm_data_req`=0 and no refill pending, the block drives `ibus_rd`=1 with `ibus_addr`=`fetch_addr` in the same cycle. It returns `ibus_rdata` on `instr_word` with `instr_valid`=1 and `fetch_stall`=0. With `fetch_req`=0 and no refill pending, `ibus_rd`=0 and `instr_valid`=0.
- R2: In a cycle with `fetch_req`=1 and `pm_data_req`=1 and no refill pending (a conflict), `ibus_rd` stays 0 so the data transfer owns the bus.
- R3: A conflict that hits returns the cached word on `instr_word` with `instr_valid`=1 and `fetch_stall`=0 in that same cycle.
- R4: A conflict that misses gives `fetch_stall`=1 and `instr_valid`=0 in that cycle. In the next cycle (the refill) the block drives `ibus_rd`=1 at the address held from the miss and delivers `ibus_rdata` with `instr_valid`=1 and `fetch_stall`=0. The sequencer inputs are ignored in the refill cycle. The block never stalls in two consecutive cycles.
- R5: A refill made with `cache_en`=1 and `flush`=0 stores the word, so a later conflict on the same address hits.
- R6: A fetch with no conflict never allocates an entry, so a following conflict on that address misses.
- R7: A fetch with no conflict does not look up the cache and does not change the replacement bit of any set.
- R8: Each set keeps one replacement bit naming its victim way, and reset sets it to way 0. A conflict hit or a refill into a way makes the other way the victim. A refill always writes the victim way, even when the other way is invalid.
- R9: The set is selected by `fetch_addr[3:0]` and the tag is `fetch_addr[23:4]`. Two addresses with the same low 4 bits can be held together in one set. The same tag in a different set is a separate entry.
- R10: With `cache_en`=0, every conflict misses and its refill stores nothing. Entries already stored stay valid and hit again once `cache_en` returns to 1.
- R11: `flush`=1 clears every valid bit at the next clock edge. A refill in the same cycle as `flush` stores nothing.
- R12: Reset clears every entry, leaves no refill pending and sets every replacement bit to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_en | input | 1 | 1 allows hits and allocation |
| flush | input | 1 | Invalidate all entries |
| fetch_req | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | 24 | Instruction address |
| pm_data_req | input | 1 | A data transfer uses the program bus this cycle |
| ibus_rd | output | 1 | Instruction read on the program bus |
| ibus_addr | output | 24 | Address of the instruction read |
| ibus_rdata | input | 48 | Word returned by the bus in the same cycle |
| instr_valid | output | 1 | `instr_word` is valid this cycle |
| instr_word | output | 48 | Instruction delivered to the sequencer |
| fetch_stall | output | 1 | Sequencer must hold its fetch one cycle |

## Verification
The cases that matter are the cycles in which an instruction fetch and a program-bus data transfer fall together. The bench creates them by raising `fetch_req` and `pm_data_req` in the same cycle on chosen addresses. It judges each cycle by `fetch_stall` and `ibus_rd`, which show a hit, a miss or a refill, and by the delivered word. Sequences of conflicts in one set, with no-conflict fetches mixed in, check the victim choice and the rule that fetches without a conflict are never stored. `cache_en` and `flush` are also applied in the cycle of a conflict and in the cycle of a refill.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int unsigned CIC_WAYS = 2;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_REFILL = 1'b1
    } cic_state_e;
endpackage

// File: rtl/cic_store.sv
module cic_store #(
    parameter int unsigned SETS   = 16,
    parameter int unsigned TAG_W  = 20,
    parameter int unsigned DATA_W = 48,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          flush,
    input  logic [IDX_W-1:0]                              set_idx,
    input  logic                                          wr_en,
    input  logic                                          wr_way,
    input  logic [TAG_W-1:0]                              wr_tag,
    input  logic [DATA_W-1:0]                             wr_data,
    input  logic                                          lru_upd,
    input  logic                                          used_way,
    output logic [cic_pkg::CIC_WAYS-1:0]                  rd_valid,
    output logic [cic_pkg::CIC_WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [cic_pkg::CIC_WAYS-1:0][DATA_W-1:0]      rd_data,
    output logic                                          rd_lru
);
    localparam int unsigned WAYS = cic_pkg::CIC_WAYS;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0]                       lru;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lru_upd) begin
            st_d.lru[set_idx] = ~used_way;
        end
        if (wr_en) begin
            st_d.valid[set_idx][wr_way] = 1'b1;
            st_d.tag[set_idx][wr_way]   = wr_tag;
            st_d.data[set_idx][wr_way]  = wr_data;
        end
        if (flush) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid[set_idx];
    assign rd_tag   = st_q.tag[set_idx];
    assign rd_data  = st_q.data[set_idx];
    assign rd_lru   = st_q.lru[set_idx];
endmodule

// File: rtl/cic_lookup.sv
module cic_lookup #(
    parameter int unsigned TAG_W  = 20,
    parameter int unsigned DATA_W = 48
) (
    input  logic                                     en,
    input  logic [TAG_W-1:0]                         tag,
    input  logic [cic_pkg::CIC_WAYS-1:0]             rd_valid,
    input  logic [cic_pkg::CIC_WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic [cic_pkg::CIC_WAYS-1:0][DATA_W-1:0] rd_data,
    output logic                                     hit_any,
    output logic                                     hit_way,
    output logic [DATA_W-1:0]                        hit_data
);
    localparam int unsigned WAYS = cic_pkg::CIC_WAYS;

    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w] = en && rd_valid[w] && (rd_tag[w] == tag);
    end

    assign hit_any  = |way_hit;
    assign hit_way  = way_hit[1];
    assign hit_data = way_hit[1] ? rd_data[1] : rd_data[0];
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              pm_data_req,
    input  logic [DATA_W-1:0] ibus_rdata,
    input  logic              hit_any,
    input  logic              hit_way,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              victim_way,
    output logic [ADDR_W-1:0] look_addr,
    output logic              ibus_rd,
    output logic [ADDR_W-1:0] ibus_addr,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_word,
    output logic              fetch_stall,
    output logic              wr_en,
    output logic              wr_way,
    output logic              lru_upd,
    output logic              used_way
);
    import cic_pkg::*;

    typedef struct packed {
        cic_state_e        state;
        logic [ADDR_W-1:0] pend;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    always_comb begin
        ct_d        = ct_q;
        look_addr   = fetch_addr;
        ibus_rd     = 1'b0;
        ibus_addr   = fetch_addr;
        instr_valid = 1'b0;
        instr_word  = ibus_rdata;
        fetch_stall = 1'b0;
        wr_en       = 1'b0;
        wr_way      = victim_way;
        lru_upd     = 1'b0;
        used_way    = victim_way;

        if (ct_q.state == ST_REFILL) begin
            look_addr   = ct_q.pend;
            ibus_rd     = 1'b1;
            ibus_addr   = ct_q.pend;
            instr_valid = 1'b1;
            wr_en       = cache_en && !flush;
            lru_upd     = cache_en && !flush;
            ct_d.state  = ST_RUN;
        end else if (fetch_req && !pm_data_req) begin
            ibus_rd     = 1'b1;
            instr_valid = 1'b1;
        end else if (fetch_req && pm_data_req) begin
            if (hit_any) begin
                instr_valid = 1'b1;
                instr_word  = hit_data;
                lru_upd     = 1'b1;
                used_way    = hit_way;
            end else begin
                fetch_stall = 1'b1;
                ct_d.state  = ST_REFILL;
                ct_d.pend   = fetch_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '{state: ST_RUN, pend: '0};
        end else begin
            ct_q <= ct_d;
        end
    end
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 48,
    parameter int unsigned SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              pm_data_req,
    output logic              ibus_rd,
    output logic [ADDR_W-1:0] ibus_addr,
    input  logic [DATA_W-1:0] ibus_rdata,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_word,
    output logic              fetch_stall
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam int unsigned WAYS  = cic_pkg::CIC_WAYS;

    logic [ADDR_W-1:0]                look_addr;
    logic [WAYS-1:0]                  rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]       rd_tag;
    logic [WAYS-1:0][DATA_W-1:0]      rd_data;
    logic                             rd_lru;
    logic                             hit_any, hit_way;
    logic [DATA_W-1:0]                hit_data;
    logic                             wr_en, wr_way, lru_upd, used_way;

    cic_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .pm_data_req(pm_data_req),
        .ibus_rdata(ibus_rdata), .hit_any(hit_any), .hit_way(hit_way),
        .hit_data(hit_data), .victim_way(rd_lru), .look_addr(look_addr),
        .ibus_rd(ibus_rd), .ibus_addr(ibus_addr), .instr_valid(instr_valid),
        .instr_word(instr_word), .fetch_stall(fetch_stall), .wr_en(wr_en),
        .wr_way(wr_way), .lru_upd(lru_upd), .used_way(used_way)
    );

    cic_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set_idx(look_addr[IDX_W-1:0]), .wr_en(wr_en), .wr_way(wr_way),
        .wr_tag(look_addr[ADDR_W-1:IDX_W]), .wr_data(ibus_rdata),
        .lru_upd(lru_upd), .used_way(used_way), .rd_valid(rd_valid),
        .rd_tag(rd_tag), .rd_data(rd_data), .rd_lru(rd_lru)
    );

    cic_lookup #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
        .en(cache_en), .tag(look_addr[ADDR_W-1:IDX_W]), .rd_valid(rd_valid),
        .rd_tag(rd_tag), .rd_data(rd_data), .hit_any(hit_any),
        .hit_way(hit_way), .hit_data(hit_data)
    );
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic              pm_data_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              ibus_rd,
    input logic [ADDR_W-1:0] ibus_addr,
    input logic              instr_valid,
    input logic              fetch_stall
);
    logic prev_stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_stall_q <= 1'b0;
        end else begin
            prev_stall_q <= fetch_stall;
        end
    end

    AST_PLAIN_FETCH_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !pm_data_req && !prev_stall_q) |-> (ibus_rd && ibus_addr == fetch_addr && instr_valid && !fetch_stall)); // R1
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !prev_stall_q) |-> (!ibus_rd && !instr_valid)); // R1
    AST_CONFLICT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && pm_data_req && !prev_stall_q) |-> !ibus_rd); // R2
    AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> !instr_valid); // R4
    AST_REFILL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (ibus_rd && instr_valid && !fetch_stall)); // R4
    AST_REFILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (ibus_addr == $past(fetch_addr))); // R4
endmodule

bind conflict_icache cic_checker #(.ADDR_W(ADDR_W)) u_cic_checker (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .pm_data_req(pm_data_req),
    .fetch_addr(fetch_addr), .ibus_rd(ibus_rd), .ibus_addr(ibus_addr),
    .instr_valid(instr_valid), .fetch_stall(fetch_stall)
);

// File: tb/tb_conflict_icache.sv
module tb_conflict_icache;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 44;

    typedef struct packed {
        logic [3:0]  req;
        logic        fr, dr, en, fl;
        logic [23:0] a;
        logic        es, ev, eb;
    } vec_t;

    localparam logic H = 1'b1;
    localparam logic L = 1'b0;
    localparam logic [23:0] AA = 24'h000103, AB = 24'h000203, AC = 24'h000303;
    localparam logic [23:0] AD = 24'h000403, AE = 24'h000104, AF = 24'h000505;
    localparam logic [23:0] AH = 24'hFFFFF3;

    // fields: req, fetch, data, enable, flush, addr, exp stall, exp valid, exp bus read
    localparam vec_t VEC [NVEC] = '{
        '{4'd1,  H,L,H,L, AA, L,H,H},  // R1 plain fetch on bus
        '{4'd6,  H,H,H,L, AA, H,L,L},  // R6 R2 conflict misses: plain fetch did not allocate
        '{4'd4,  H,L,H,L, AA, L,H,H},  // R4 refill
        '{4'd5,  H,H,H,L, AA, L,H,L},  // R5 R3 conflict hit
        '{4'd1,  L,L,H,L, AA, L,L,L},  // R1 idle
        '{4'd2,  L,H,H,L, AA, L,L,L},  // R2 data only
        '{4'd8,  H,H,H,L, AB, H,L,L},  // R8 miss B
        '{4'd8,  H,L,H,L, AB, L,H,H},  // R8 refill B way1
        '{4'd8,  H,H,H,L, AA, L,H,L},  // R8 hit A refreshes
        '{4'd8,  H,H,H,L, AC, H,L,L},  // R8 miss C
        '{4'd8,  H,L,H,L, AC, L,H,H},  // R8 refill C evicts B
        '{4'd8,  H,H,H,L, AA, L,H,L},  // R8 A survived
        '{4'd8,  H,H,H,L, AB, H,L,L},  // R8 B evicted
        '{4'd8,  H,L,H,L, AB, L,H,H},  // R8 refill B evicts C
        '{4'd7,  H,L,H,L, AA, L,H,H},  // R7 plain fetch A, no LRU touch
        '{4'd7,  H,H,H,L, AD, H,L,L},  // R7 miss D
        '{4'd7,  H,L,H,L, AD, L,H,H},  // R7 refill D evicts A
        '{4'd7,  H,H,H,L, AB, L,H,L},  // R7 B survived
        '{4'd7,  H,H,H,L, AA, H,L,L},  // R7 A evicted
        '{4'd7,  H,L,H,L, AA, L,H,H},  // R7 refill A
        '{4'd9,  H,H,H,L, AE, H,L,L},  // R9 same tag other set misses
        '{4'd9,  H,L,H,L, AE, L,H,H},  // R9 refill
        '{4'd9,  H,H,H,L, AE, L,H,L},  // R9 hit set 4
        '{4'd9,  H,H,H,L, AA, L,H,L},  // R9 set 3 untouched
        '{4'd10, H,H,L,L, AA, H,L,L},  // R10 disabled forces miss
        '{4'd10, H,L,L,L, AA, L,H,H},  // R10 refill
        '{4'd10, H,H,H,L, AA, L,H,L},  // R10 entry kept
        '{4'd10, H,H,L,L, AF, H,L,L},  // R10 miss F disabled
        '{4'd10, H,L,L,L, AF, L,H,H},  // R10 refill no allocation
        '{4'd10, H,H,H,L, AF, H,L,L},  // R10 still misses
        '{4'd10, H,L,H,L, AF, L,H,H},  // R10 refill allocates
        '{4'd5,  H,H,H,L, AF, L,H,L},  // R5 hit F
        '{4'd11, L,L,H,H, AF, L,L,L},  // R11 flush
        '{4'd11, H,H,H,L, AF, H,L,L},  // R11 F gone
        '{4'd11, H,L,H,L, AF, L,H,H},  // R11 refill
        '{4'd11, H,H,H,L, AE, H,L,L},  // R11 E gone
        '{4'd11, H,L,H,L, AE, L,H,H},  // R11 refill
        '{4'd11, H,H,H,L, AA, H,L,L},  // R11 A gone
        '{4'd11, H,L,H,H, AA, L,H,H},  // R11 refill during flush
        '{4'd11, H,H,H,L, AA, H,L,L},  // R11 flush won
        '{4'd11, H,L,H,L, AA, L,H,H},  // R11 refill
        '{4'd9,  H,H,H,L, AH, H,L,L},  // R9 high tag miss
        '{4'd9,  H,L,H,L, AH, L,H,H},  // R9 refill
        '{4'd9,  H,H,H,L, AH, L,H,L}   // R9 high tag hit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1, flush = 1'b0, fetch_req = 1'b0, pm_data_req = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        ibus_rd, instr_valid, fetch_stall;
    logic [23:0] ibus_addr;
    logic [47:0] ibus_rdata, instr_word;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [47:0] mem_word(input logic [23:0] a);
        return {a ^ 24'h5A5A5A, a};
    endfunction

    assign ibus_rdata = mem_word(ibus_addr);

    conflict_icache dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .pm_data_req(pm_data_req),
        .ibus_rd(ibus_rd), .ibus_addr(ibus_addr), .ibus_rdata(ibus_rdata),
        .instr_valid(instr_valid), .instr_word(instr_word), .fetch_stall(fetch_stall)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic fr, input logic dr, input logic en,
                         input logic fl, input logic [23:0] a);
        @(posedge clk);
        #1;
        fetch_req = fr; pm_data_req = dr; cache_en = en; flush = fl; fetch_addr = a;
    endtask

    task automatic expect_out(input string req, input logic es, input logic ev,
                              input logic eb, input logic [23:0] a);
        @(negedge clk);
        check(req, "fetch_stall", 64'(fetch_stall), 64'(es));
        check(req, "instr_valid", 64'(instr_valid), 64'(ev));
        check(req, "ibus_rd", 64'(ibus_rd), 64'(eb));
        if (eb) check(req, "ibus_addr", 64'(ibus_addr), 64'(a));
        if (ev) check(req, "instr_word", 64'(instr_word), 64'(mem_word(a)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: idle after reset, no refill pending
        expect_out("R12", L, L, L, AA);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].fr, VEC[i].dr, VEC[i].en, VEC[i].fl, VEC[i].a);
            expect_out($sformatf("R%0d row %0d", VEC[i].req, i),
                       VEC[i].es, VEC[i].ev, VEC[i].eb, VEC[i].a);
        end

        // R12: reset while a refill is pending drops the refill and the contents
        drive(H, H, H, L, 24'h000606);
        expect_out("R12", H, L, L, 24'h000606);
        #1 rst_n = 1'b0;
        drive(L, L, H, L, AH);
        #1 rst_n = 1'b1;
        expect_out("R12", L, L, L, AH);
        drive(H, H, H, L, AH);
        expect_out("R12", H, L, L, AH);
        drive(H, L, H, L, AH);
        expect_out("R4", L, H, H, AH);
        drive(H, H, H, L, AH);
        expect_out("R3", L, H, L, AH);
        drive(L, L, H, L, AH);
        expect_out("R1", L, L, L, AH);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule